// File: doc/BRIEF.md
# Four-Rail Power Sequencer

This block turns on three supply-rail enables one after another and then raises a power-good flag. Each of its four inputs is a single-bit comparator result that reads high while the rail it watches is above threshold. The first input can also be driven by a plain logic start signal. The first stage is held back by a programmable delay. The delay is given in milliseconds and converted to clock cycles from a clock-frequency parameter.

The state machine has five states: waiting, stage 1, stage 2, stage 3 and power good. Once the sequence has finished, faults are handled in two ways:

- If the first rail is lost, all outputs go low and the sequence starts again from waiting.
- If any other rail is lost, only power good drops. The machine then waits in stage 3 with all enables held until every rail is back.

All four inputs are asynchronous, so each one passes through a two-flop synchroniser before the state machine uses it.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with `rail_ok[0]` low, `rail_en` is 3'b000 and `pwr_good` is 0.
- R2: `rail_en[0]` rises exactly `DLY_CYC`+2 clock edges after `rail_ok[0]` rises, where `DLY_CYC` = (`CLK_HZ`/1000)*`DELAY_MS`. The extra two edges are the synchroniser. It stays low on the edge before.
- R3: With `rail_en[0]` high, a rise of `rail_ok[1]` sets `rail_en[1]` three edges later.
- R4: `rail_en[2]` is set only after `rail_en[1]`, following a high `rail_ok[2]`. A high `rail_ok[2]` seen while `rail_en[1]` is still low has no effect.
- R5: With `rail_en` = 3'b111, `pwr_good` rises only after all four `rail_ok` bits have been high at the synchroniser output.
- R6: In power good, a drop of `rail_ok[1]`, `rail_ok[2]` or `rail_ok[3]` while `rail_ok[0]` stays high clears `pwr_good` three edges later. `rail_en` stays at 3'b111, and `pwr_good` returns once all four inputs are high again.
- R7: A drop of `rail_ok[0]` in any state clears `rail_en` and `pwr_good` three edges later. Nothing rises again until `rail_ok[0]` is high, and the restart begins with the full delay of R2.
- R8: If `rail_ok[0]` drops while the delay is counting, the count is discarded. The next rise waits the full delay again.
- R9: The outputs are always nested: `pwr_good` implies `rail_en[2]`, `rail_en[2]` implies `rail_en[1]`, and `rail_en[1]` implies `rail_en[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_ok | input | 4 | Comparator results; bit 0 is the first rail (or the start signal) |
| rail_en | output | 3 | Stage enables; bit 0 is the first stage |
| pwr_good | output | 1 | High when the whole sequence is complete and all rails are good |

## Verification
The bench builds the block with `CLK_HZ` = 10000 and `DELAY_MS` = 1, which gives a ten-cycle first-stage delay. This short delay puts the exact enable edge of R2 within reach of a direct check. It also lets the bench drop the first rail part-way through a count (R8). A full restart after a first-rail fault (R7) then fits in a few dozen cycles, and the default delay would take millions.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DELAY_MS = 190
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rail_ok,
  output logic [2:0] rail_en,
  output logic       pwr_good
);
  localparam int DLY_CYC = (CLK_HZ / 1000) * DELAY_MS;
  localparam int CW      = (DLY_CYC > 1) ? $clog2(DLY_CYC + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  typedef enum logic [2:0] {S_WAIT, S_ST1, S_ST2, S_ST3, S_GOOD} st_t;

  st_t           st, nxt;
  logic [3:0]    meta, sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= rail_ok;
      sync <= meta;
    end

  always_comb begin
    nxt = st;
    case (st)
      S_WAIT: if (cnt == LAST) nxt = S_ST1;
      S_ST1:  if (sync[1]) nxt = S_ST2;
      S_ST2:  if (sync[2]) nxt = S_ST3;
      S_ST3:  if (&sync) nxt = S_GOOD;
      S_GOOD: if (!(&sync)) nxt = S_ST3;
      default: nxt = S_WAIT;
    endcase
    if (!sync[0]) nxt = S_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (st != S_WAIT || !sync[0]) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

  assign rail_en[0] = (st != S_WAIT);
  assign rail_en[1] = (st == S_ST2) || (st == S_ST3) || (st == S_GOOD);
  assign rail_en[2] = (st == S_ST3) || (st == S_GOOD);
  assign pwr_good   = (st == S_GOOD);

  assert_en1_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[0]) |-> ($past(cnt) == LAST && $past(sync[0])));

  assert_pg_needs_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(&sync));

  assert_hold_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && sync[0] && !(&sync)) |=> (rail_en == 3'b111 && !pwr_good));

  assert_first_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync[0] |=> (rail_en == 3'b000 && !pwr_good));

  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rail_en[0] && !sync[0]) |=> (cnt == '0));

  assert_nested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good || rail_en[2]) && (!rail_en[2] || rail_en[1]) && (!rail_en[1] || rail_en[0]));
endmodule

// File: tb/tb_rail_sequencer.sv
module tb_rail_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rail_ok = '0;
  logic [2:0] rail_en;
  logic       pwr_good;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  rail_sequencer #(.CLK_HZ(10_000), .DELAY_MS(1)) dut (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .rail_en(rail_en), .pwr_good(pwr_good));

  always #2 clk = ~clk;

  // {rails[3:0], wait edges[7:0], expected {pg,en3,en2,en1}}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 8'd4,  4'b0000},  // R1 idle
    {4'b0001, 8'd11, 4'b0000},  // R2 one edge before delay ends
    {4'b0001, 8'd1,  4'b0001},  // R2 enable 1 on exact edge
    {4'b0101, 8'd4,  4'b0001},  // R4 rail 3 before rail 2 ignored
    {4'b0111, 8'd3,  4'b0011},  // R3 enable 2
    {4'b0111, 8'd1,  4'b0111},  // R4 enable 3 follows
    {4'b1111, 8'd3,  4'b1111},  // R5 power good
    {4'b1101, 8'd3,  4'b0111},  // R6 rail 2 lost
    {4'b1111, 8'd3,  4'b1111},  // R6 recovery
    {4'b0111, 8'd3,  4'b0111},  // R6 rail 4 lost
    {4'b1111, 8'd3,  4'b1111},  // R6 recovery
    {4'b1110, 8'd3,  4'b0000},  // R7 first rail lost
    {4'b1110, 8'd20, 4'b0000},  // R7 stays down
    {4'b1111, 8'd11, 4'b0000},  // R7 full delay on restart
    {4'b1111, 8'd1,  4'b0001},  // R7 enable 1
    {4'b1111, 8'd1,  4'b0011},  // R9 one stage per edge
    {4'b1111, 8'd1,  4'b0111},  // R9
    {4'b1111, 8'd1,  4'b1111},  // R5
    {4'b0000, 8'd3,  4'b0000},  // R7
    {4'b0001, 8'd5,  4'b0000},  // R8 partial count
    {4'b0000, 8'd3,  4'b0000},  // R8 drop mid-count
    {4'b0001, 8'd11, 4'b0000},  // R8 count restarted
    {4'b0001, 8'd1,  4'b0001}   // R8 full delay
  };

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {pwr_good, rail_en};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100_000) begin
        fails++;
        $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rail_ok = 4'b1111;
    edges(3);
    check(4'b0000, "R1 in reset");
    rail_ok = 4'b0000;
    rst_n = 1'b1;
    edges(2);
    check(4'b0000, "R1 after release");
    for (int v = 0; v < NV; v++) begin
      rail_ok = VEC[v][15:12];
      edges(int'(VEC[v][11:4]));
      check(VEC[v][3:0], $sformatf("vector %0d", v));
    end
    rail_ok = 4'b1111;
    edges(6);
    check(4'b1111, "R5 before reset");
    rst_n = 1'b0;
    #1;
    check(4'b0000, "R1 async reset");
    edges(1);
    rst_n = 1'b1;
    edges(11);
    check(4'b0000, "R2 delay after reset");
    edges(1);
    check(4'b0001, "R2 enable after reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule